// File: doc/BRIEF.md
# Double-Data-Rate Pad Register Cell

This cell sits between the core and one pad (or a group of `W` pads) and registers all three pad-side paths on two clock phases. On the receive side, two registers sample the pad, one on the rising edge of each input clock. The core therefore gets two bits per input-clock period. On the transmit side, two data registers and two enable registers load on the rising edges of the two output clocks. A double-data-rate multiplexer, steered by the first output clock, picks between the two registers of each pair. This lets the pad carry two bits, and change its drive state twice, in each output-clock period.

The receive side and the transmit side have separate clocks and separate clock enables. One synchronous set and one synchronous reset are shared by all six registers, and each register acts on them at its own clock edge. The pad enable is active low. The cell presents the data and the enable to the pad driver as plain outputs. When the enable is high, the pad floats.

Top module: `ddr_pad_cell`

## Requirements
- R1: With `rx_ce` high, `rx_q_a` takes `pad_in` at each rising edge of `rx_clk_a`, and `rx_q_b` takes `pad_in` at each rising edge of `rx_clk_b`.
- R2: With `tx_ce` high, the first data register loads `tx_d_a` at each rising edge of `tx_clk_a`, and the second data register loads `tx_d_b` at each rising edge of `tx_clk_b`.
- R3: `pad_out` shows the first data register while `tx_clk_a` is 1, and the second data register while `tx_clk_a` is 0.
- R4: The enable pair loads `oe_n_a` and `oe_n_b` on the same edges as the data pair. `pad_oe_n` is multiplexed by `tx_clk_a` in the same way as the data. The value 0 means drive and 1 means high impedance.
- R5: With `rx_ce` low, both receive registers hold their values, even while the transmit side keeps updating the pad.
- R6: With `tx_ce` low, all four transmit registers hold their values, whatever the data and enable inputs do.
- R7: `cell_rst` high clears every register to 0 at that register's own clock edge, whatever the clock enables are.
- R8: `cell_set` high (with `cell_rst` low) sets every register to all ones at its own clock edge, whatever the clock enables are.
- R9: When `cell_rst` and `cell_set` are both high, reset wins and the registers go to 0.
- R10: When the pad is looped back to the input and the input clocks sample the middle of each half of the output period, the two captured bits equal the two transmitted bits. A half in which the enable is 1 reads the pulled-up level, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk_a | input | 1 | First receive clock |
| rx_clk_b | input | 1 | Second receive clock |
| rx_ce | input | 1 | Receive clock enable |
| tx_clk_a | input | 1 | First transmit clock; also steers the DDR multiplexers |
| tx_clk_b | input | 1 | Second transmit clock |
| tx_ce | input | 1 | Transmit clock enable (data and enable pairs) |
| tx_d_a | input | W | Data for the first half of the period |
| tx_d_b | input | W | Data for the second half of the period |
| oe_n_a | input | W | Active-low drive enable for the first half |
| oe_n_b | input | W | Active-low drive enable for the second half |
| cell_set | input | 1 | Shared synchronous set |
| cell_rst | input | 1 | Shared synchronous reset; has priority over set |
| pad_in | input | W | Level seen at the pad |
| pad_out | output | W | Multiplexed data to the pad driver |
| pad_oe_n | output | W | Multiplexed active-low drive enable to the pad driver |
| rx_q_a | output | W | Pad sample from `rx_clk_a` |
| rx_q_b | output | W | Pad sample from `rx_clk_b` |

## Verification
The hardest case to reach is a half-period in which the pad floats while the other half drives. To show it, the receive register for the floating half must read the pulled-up level, and the other register must still read the driven bit. The bench models the pad as a loopback with a pull-up. It places the receive clock edges a quarter period after each transmit edge, so each sample lands in the middle of a stable half. It then sends enable pairs that differ between the two halves. Hold behaviour is checked with the same loopback: one side's enable is dropped while the other side keeps running, and the bench confirms that the frozen side does not move.

// File: rtl/ddr_pad_cell.sv
module ddr_pad_cell #(
  parameter int W = 1
) (
  input  logic         rx_clk_a,
  input  logic         rx_clk_b,
  input  logic         rx_ce,
  input  logic         tx_clk_a,
  input  logic         tx_clk_b,
  input  logic         tx_ce,
  input  logic [W-1:0] tx_d_a,
  input  logic [W-1:0] tx_d_b,
  input  logic [W-1:0] oe_n_a,
  input  logic [W-1:0] oe_n_b,
  input  logic         cell_set,
  input  logic         cell_rst,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe_n,
  output logic [W-1:0] rx_q_a,
  output logic [W-1:0] rx_q_b
);

  logic [W-1:0] dq_a, dq_b, eq_a, eq_b;

  function automatic logic [W-1:0] nxt(input logic [W-1:0] cur, input logic [W-1:0] d,
                                       input logic ce, input logic s, input logic r);
    if (r)       return '0;
    else if (s)  return '1;
    else if (ce) return d;
    else         return cur;
  endfunction

  always_ff @(posedge rx_clk_a) rx_q_a <= nxt(rx_q_a, pad_in, rx_ce, cell_set, cell_rst);
  always_ff @(posedge rx_clk_b) rx_q_b <= nxt(rx_q_b, pad_in, rx_ce, cell_set, cell_rst);

  always_ff @(posedge tx_clk_a) begin
    dq_a <= nxt(dq_a, tx_d_a, tx_ce, cell_set, cell_rst);
    eq_a <= nxt(eq_a, oe_n_a, tx_ce, cell_set, cell_rst);
  end

  always_ff @(posedge tx_clk_b) begin
    dq_b <= nxt(dq_b, tx_d_b, tx_ce, cell_set, cell_rst);
    eq_b <= nxt(eq_b, oe_n_b, tx_ce, cell_set, cell_rst);
  end

  assign pad_out  = tx_clk_a ? dq_a : dq_b;
  assign pad_oe_n = tx_clk_a ? eq_a : eq_b;

  AST_RXA_CAPTURE: assert property (@(posedge rx_clk_a) disable iff (cell_rst)
    (rx_ce && !cell_set) |=> (rx_q_a == $past(pad_in))); // R1
  AST_RXB_CAPTURE: assert property (@(posedge rx_clk_b) disable iff (cell_rst)
    (rx_ce && !cell_set) |=> (rx_q_b == $past(pad_in))); // R1
  AST_RX_HOLD: assert property (@(posedge rx_clk_a) disable iff (cell_rst)
    (!rx_ce && !cell_set) |=> $stable(rx_q_a)); // R5
  AST_TX_HOLD: assert property (@(posedge tx_clk_b) disable iff (cell_rst)
    (!tx_ce && !cell_set) |=> ($stable(dq_b) && $stable(eq_b))); // R6
  AST_TX_LOAD: assert property (@(posedge tx_clk_a) disable iff (cell_rst)
    (tx_ce && !cell_set) |=> (dq_a == $past(tx_d_a) && eq_a == $past(oe_n_a))); // R2
  AST_SET_ONES: assert property (@(posedge tx_clk_a) disable iff (cell_rst)
    cell_set |=> (&dq_a && &eq_a)); // R8

endmodule

// File: tb/sim_ddr_pad_cell.sv
module sim_ddr_pad_cell;
  localparam int CLK_PERIOD = 20;
  localparam int Q = CLK_PERIOD / 4;

  logic rx_clk_a = 0, rx_clk_b = 0, tx_clk_a = 0, tx_clk_b = 0;
  logic rx_ce = 1, tx_ce = 1, cell_set = 0, cell_rst = 1;
  logic [0:0] tx_d_a = 1, tx_d_b = 1, oe_n_a = 1, oe_n_b = 1;
  logic [0:0] pad_in, pad_out, pad_oe_n, rx_q_a, rx_q_b;
  int total = 0, bad = 0;

  assign pad_in = pad_oe_n[0] ? 1'b1 : pad_out;

  ddr_pad_cell #(.W(1)) u0 (
    .rx_clk_a(rx_clk_a), .rx_clk_b(rx_clk_b), .rx_ce(rx_ce),
    .tx_clk_a(tx_clk_a), .tx_clk_b(tx_clk_b), .tx_ce(tx_ce),
    .tx_d_a(tx_d_a), .tx_d_b(tx_d_b), .oe_n_a(oe_n_a), .oe_n_b(oe_n_b),
    .cell_set(cell_set), .cell_rst(cell_rst), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe_n(pad_oe_n), .rx_q_a(rx_q_a), .rx_q_b(rx_q_b));

  initial forever begin
    tx_clk_a = 1; tx_clk_b = 0; #Q;
    rx_clk_a = 1; rx_clk_b = 0; #Q;
    tx_clk_a = 0; tx_clk_b = 1; #Q;
    rx_clk_a = 0; rx_clk_b = 1; #Q;
  end

  task automatic chk(input string tag, input logic [0:0] act, input logic [0:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic hi_phase(); @(posedge tx_clk_a); #2; endtask

  task automatic all_regs(input string tag, input logic [0:0] v);
    chk({tag, " pad_out hi"}, pad_out, v);
    chk({tag, " pad_oe_n hi"}, pad_oe_n, v);
    #10;
    chk({tag, " pad_out lo"}, pad_out, v);
    chk({tag, " pad_oe_n lo"}, pad_oe_n, v);
    chk({tag, " rx_q_a"}, rx_q_a, v);
    chk({tag, " rx_q_b"}, rx_q_b, v);
  endtask

  task automatic t_reset();
    repeat (3) hi_phase();
    all_regs("R7 reset", 1'b0);
  endtask

  task automatic t_set_no_ce();
    hi_phase(); cell_rst = 0; cell_set = 1; rx_ce = 0; tx_ce = 0;
    repeat (2) hi_phase();
    all_regs("R8 set", 1'b1);
  endtask

  task automatic t_rst_over_set();
    hi_phase(); cell_rst = 1; cell_set = 1;
    repeat (2) hi_phase();
    all_regs("R9 R7 reset over set", 1'b0);
    hi_phase(); cell_rst = 0; cell_set = 0; rx_ce = 1; tx_ce = 1;
  endtask

  task automatic t_send(input logic [0:0] a, input logic [0:0] b,
                        input logic [0:0] ea, input logic [0:0] eb);
    hi_phase(); tx_d_a = a; tx_d_b = b; oe_n_a = ea; oe_n_b = eb;
    hi_phase();
    chk("R3 R2 pad_out high phase", pad_out, a);
    chk("R4 pad_oe_n high phase", pad_oe_n, ea);
    #10;
    chk("R3 R2 pad_out low phase", pad_out, b);
    chk("R4 pad_oe_n low phase", pad_oe_n, eb);
    hi_phase();
    chk("R10 R1 rx_q_a loopback", rx_q_a, ea ? 1'b1 : a);
    chk("R10 R1 rx_q_b loopback", rx_q_b, eb ? 1'b1 : b);
  endtask

  task automatic t_tx_hold();
    t_send(1, 0, 0, 0);
    hi_phase(); tx_ce = 0; tx_d_a = 0; tx_d_b = 1; oe_n_a = 1; oe_n_b = 1;
    repeat (2) hi_phase();
    chk("R6 held pad_out high", pad_out, 1'b1);
    chk("R6 held pad_oe_n high", pad_oe_n, 1'b0);
    #10;
    chk("R6 held pad_out low", pad_out, 1'b0);
    chk("R6 held pad_oe_n low", pad_oe_n, 1'b0);
    hi_phase(); tx_ce = 1;
  endtask

  task automatic t_rx_hold();
    t_send(1, 0, 0, 0);
    hi_phase(); rx_ce = 0; tx_d_a = 0; tx_d_b = 1; oe_n_a = 0; oe_n_b = 0;
    hi_phase();
    chk("R5 pad still updates", pad_out, 1'b0);
    hi_phase();
    chk("R5 rx_q_a held", rx_q_a, 1'b1);
    chk("R5 rx_q_b held", rx_q_b, 1'b0);
    hi_phase(); rx_ce = 1;
    hi_phase();
    chk("R5 R1 rx_q_a resumes", rx_q_a, 1'b0);
    chk("R5 R1 rx_q_b resumes", rx_q_b, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_set_no_ce();
    t_rst_over_set();
    t_send(0, 1, 0, 0);
    t_send(1, 0, 0, 0);
    t_send(1, 1, 0, 0);
    t_send(0, 0, 0, 0);
    t_send(0, 0, 1, 0);
    t_send(1, 0, 0, 1);
    t_tx_hold();
    t_rx_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule